// File: doc/BRIEF.md
# Blanking-Window PLL Rate Switch Sequencer

This block changes the output frequency of a display PLL without disturbing the visible picture. Software asks for a switch by flipping a request bit. Flipping it from 0 to 1 and flipping it from 1 to 0 both count as a request. The block then waits for the next start of vertical blanking. At that point it turns the PLL off and copies the newly staged divider fields into the active divider register. At the next line boundary it turns the PLL back on. A `busy` flag covers the whole time from the request until the PLL is enabled again.

Dividers are double buffered. Software may rewrite the staging value at any time. Only the value present at the clock edge that starts a switch is copied into the active register. Switching is allowed only while the 2-bit pipe-mode input is zero. In any other mode a flip of the request bit is absorbed and causes nothing. All pins are plain control and status levels. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `pll_rate_switch`

## Requirements
- R1: While reset is held and after it is released, `pll_en` is 1, `busy` is 0 and `active_div` equals `stage_div` as sampled during reset. The level `rate_toggle` has during reset becomes the reference, so that level does not create a request.
- R2: With `pipe_mode` equal to 2'b00, a change of `rate_toggle` in either direction raises `busy` at the next clock edge. `pll_en` stays 1 until the switch actually starts.
- R3: With `pipe_mode` not equal to 2'b00, a change of `rate_toggle` leaves `busy` and `pll_en` unaffected. The new level still becomes the reference, so changing `pipe_mode` back to 2'b00 afterwards does not create a request.
- R4: A pending request acts only at a clock edge where `vblank` is 1 and was 0 at the previous edge. After that edge, `pll_en` is 0 and `active_div` holds `stage_div` as sampled at that edge. A request made while `vblank` is already high waits for the next rising edge.
- R5: `active_div` changes only at the edge that starts a switch. Changes to `stage_div` at any other time have no effect on it.
- R6: While the PLL is off, the first clock edge with `line_stb` high sets `pll_en` back to 1. `busy` falls at that same edge if no other request is waiting.
- R7: If `vblank` is sampled low while the PLL is off, `pll_en` returns to 1 at that same edge. The PLL is therefore never off outside blanking for longer than one cycle.
- R8: A toggle that arrives while `busy` is high is kept as one pending request. Any number of such toggles collapse into that one request. It is served at the first rising edge of `vblank` after the current switch has finished.
- R9: Rising edges of `vblank` and pulses on `line_stb` with no request pending leave `pll_en`, `busy` and `active_div` unchanged.
- R10: Whenever `pll_en` is 0, `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_toggle | input | 1 | Request bit; any change of its level is a switch request |
| pipe_mode | input | 2 | Pipe mode; switching is allowed only at 2'b00 |
| vblank | input | 1 | High during vertical blanking |
| line_stb | input | 1 | One-cycle pulse at each line boundary |
| stage_div | input | NUM_DIV*DIV_W | Staging copy of the divider fields |
| pll_en | output | 1 | PLL enable |
| active_div | output | NUM_DIV*DIV_W | Active divider fields |
| busy | output | 1 | Switch requested or in progress |

## Verification
Three kinds of wrong internal state would show at the ports. A lost reference level shows as a phantom or missing `busy` one cycle after the request bit flips. A sequencer that leaves its idle state at the wrong time shows as `pll_en` low outside a fresh blanking start, or as `pll_en` still low after a line pulse. A divider bank loaded at the wrong edge shows as `active_div` holding a staging value that was written before or after the start edge. The bench sweeps every pipe mode against both toggle directions. It moves the staging value before, at and after the start edge, and checks each port at the first sample after the edge where the change is due.

// File: rtl/pll_rate_switch_pkg.sv
package pll_rate_switch_pkg;

  // Pipe-mode value under which rate switching is permitted
  localparam logic [1:0] MODE_SWITCH_OK = 2'b00;

  // Sequencer states: idle/waiting, or PLL held off during blanking
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_DARK = 1'b1
  } seq_state_t;

endpackage

// File: rtl/toggle_tracker.sv
module toggle_tracker
  import pll_rate_switch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_lvl,
  input  logic [1:0] pipe_mode,
  input  logic       take,
  output logic       pend
);

  logic ref_q;
  logic pend_q;
  logic flip;
  logic mode_ok;

  assign flip    = req_lvl ^ ref_q;
  assign mode_ok = (pipe_mode == MODE_SWITCH_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= req_lvl;
      pend_q <= 1'b0;
    end else begin
      ref_q <= req_lvl;
      if (flip && mode_ok) begin
        pend_q <= 1'b1;
      end else if (take) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign pend = pend_q;

  // A request can only appear after a flip seen in the permitted mode
  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(pipe_mode) == MODE_SWITCH_OK));

endmodule

// File: rtl/blank_sequencer.sv
module blank_sequencer
  import pll_rate_switch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vblank,
  input  logic line_stb,
  input  logic pend,
  output logic take,
  output logic pll_en,
  output logic dark
);

  seq_state_t state_q;
  logic       vb_q;
  logic       en_q;
  logic       vb_rise;

  assign vb_rise = vblank & ~vb_q;
  assign take    = (state_q == SQ_IDLE) & pend & vb_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      en_q    <= 1'b1;
      vb_q    <= vblank;
    end else begin
      vb_q <= vblank;
      case (state_q)
        SQ_IDLE: begin
          if (take) begin
            state_q <= SQ_DARK;
            en_q    <= 1'b0;
          end
        end
        SQ_DARK: begin
          if (line_stb || !vblank) begin
            state_q <= SQ_IDLE;
            en_q    <= 1'b1;
          end
        end
        default: begin
          state_q <= SQ_IDLE;
          en_q    <= 1'b1;
        end
      endcase
    end
  end

  assign pll_en = en_q;
  assign dark   = (state_q == SQ_DARK);

  // PLL is only switched off at an edge where blanking is present
  assert_drop_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(vblank));

  // Blanking ending while dark forces the PLL back on at once
  assert_early_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !vblank) |=> en_q);

  // A line boundary while dark re-enables the PLL
  assert_strobe_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && line_stb) |=> en_q);

endmodule

// File: rtl/div_bank.sv
module div_bank #(
  parameter int DIV_W   = 8,
  parameter int NUM_DIV = 2,
  localparam int TOT_W  = DIV_W * NUM_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TOT_W-1:0] stage_div,
  output logic [TOT_W-1:0] active_div
);

  for (genvar gi = 0; gi < NUM_DIV; gi++) begin : g_field
    logic [DIV_W-1:0] fld_q;
    always_ff @(posedge clk) begin
      if (!rst_n || load) begin
        fld_q <= stage_div[gi*DIV_W +: DIV_W];
      end
    end
    assign active_div[gi*DIV_W +: DIV_W] = fld_q;
  end

endmodule

// File: rtl/pll_rate_switch.sv
module pll_rate_switch
  import pll_rate_switch_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int NUM_DIV = 2,
  localparam int TOT_W  = DIV_W * NUM_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_toggle,
  input  logic [1:0]       pipe_mode,
  input  logic             vblank,
  input  logic             line_stb,
  input  logic [TOT_W-1:0] stage_div,
  output logic             pll_en,
  output logic [TOT_W-1:0] active_div,
  output logic             busy
);

  logic pend;
  logic take;
  logic dark;

  toggle_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_lvl   (rate_toggle),
    .pipe_mode (pipe_mode),
    .take      (take),
    .pend      (pend)
  );

  blank_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .vblank   (vblank),
    .line_stb (line_stb),
    .pend     (pend),
    .take     (take),
    .pll_en   (pll_en),
    .dark     (dark)
  );

  div_bank #(.DIV_W(DIV_W), .NUM_DIV(NUM_DIV)) u_divs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take),
    .stage_div  (stage_div),
    .active_div (active_div)
  );

  assign busy = pend | dark;

  // Marks that at least one cycle has passed since reset released
  logic up_q;
  always_ff @(posedge clk) begin
    up_q <= rst_n;
  end

  // Active dividers move only together with the PLL being switched off
  assert_div_change_R5: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    !$stable(active_div) |-> $fell(pll_en));

  // The PLL is never off without the busy flag
  assert_busy_dark_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> busy);

endmodule

// File: tb/tb_pll_rate_switch.sv
module tb_pll_rate_switch;
  localparam int DIV_W   = 8;
  localparam int NUM_DIV = 2;
  localparam int TW      = DIV_W * NUM_DIV;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rate_toggle;
  logic [1:0]    pipe_mode;
  logic          vblank;
  logic          line_stb;
  logic [TW-1:0] stage_div;
  logic          pll_en;
  logic [TW-1:0] active_div;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  logic [TW-1:0] exp_act;

  always #10 clk = ~clk;

  pll_rate_switch #(.DIV_W(DIV_W), .NUM_DIV(NUM_DIV)) dut (
    .clk, .rst_n, .rate_toggle, .pipe_mode, .vblank, .line_stb,
    .stage_div, .pll_en, .active_div, .busy
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    line_stb = 1'b1;
    step();
    line_stb = 1'b0;
  endtask

  function automatic logic [TW-1:0] pat(input int v);
    logic [7:0] hi;
    logic [7:0] lo;
    hi = 8'(v * 37 + 5);
    lo = 8'(v * 91 + 3);
    return {hi, lo};
  endfunction

  initial begin
    #(20 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int idx;
    rst_n = 1'b0; rate_toggle = 1'b1; pipe_mode = 2'b00;
    vblank = 1'b0; line_stb = 1'b0; stage_div = pat(0);
    step(3);
    rst_n = 1'b1;
    step(2);
    exp_act = pat(0);
    chk("R1 pll_en", pll_en, 1);
    chk("R1 busy", busy, 0);
    chk("R1 active_div", active_div, exp_act);

    // Sweep all pipe modes against both toggle directions
    idx = 1;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        pipe_mode = 2'(m);
        stage_div = pat(idx);
        rate_toggle = ~rate_toggle;
        step();
        chk((m == 0) ? "R2 busy on flip" : "R3 busy ignored", busy, (m == 0));
        step(3);
        chk("R2 pll_en while waiting", pll_en, 1);
        stage_div = pat(idx + 50);
        step();
        chk("R5 active held before start", active_div, exp_act);
        vblank = 1'b1;
        step();
        if (m == 0) exp_act = pat(idx + 50);
        chk("R4 pll_en at vblank rise", pll_en, (m != 0));
        chk("R4 active_div at vblank rise", active_div, exp_act);
        stage_div = pat(idx + 77);
        step(2);
        chk("R5 active held after start", active_div, exp_act);
        chk("R6 pll_en dark until strobe", pll_en, (m != 0));
        if (m == 0) chk("R10 busy while dark", busy, 1);
        strobe();
        chk("R6 pll_en after strobe", pll_en, 1);
        chk("R6 busy after strobe", busy, 0);
        vblank = 1'b0;
        step(2);
        if (m != 0) begin
          pipe_mode = 2'b00;
          step();
          chk("R3 reference updated", busy, 0);
        end
        idx++;
      end
    end
    pipe_mode = 2'b00;

    // Request while blanking already active waits for the next rise
    vblank = 1'b1;
    step();
    rate_toggle = ~rate_toggle;
    step();
    chk("R4 busy mid-blank", busy, 1);
    strobe();
    step(2);
    chk("R4 no action mid-blank", pll_en, 1);
    vblank = 1'b0;
    step();
    vblank = 1'b1;
    stage_div = pat(200);
    step();
    exp_act = pat(200);
    chk("R4 pll_en next rise", pll_en, 0);
    chk("R4 active next rise", active_div, exp_act);
    strobe();
    chk("R6 recover", pll_en, 1);
    vblank = 1'b0;
    step();

    // Blanking ends before any line strobe
    rate_toggle = ~rate_toggle;
    step();
    stage_div = pat(201);
    vblank = 1'b1;
    step();
    exp_act = pat(201);
    chk("R7 dark", pll_en, 0);
    vblank = 1'b0;
    step();
    chk("R7 pll_en forced on", pll_en, 1);
    chk("R7 busy cleared", busy, 0);
    chk("R7 active", active_div, exp_act);

    // Toggles while busy queue as one request
    rate_toggle = ~rate_toggle;
    step();
    vblank = 1'b1;
    stage_div = pat(202);
    step();
    exp_act = pat(202);
    chk("R8 first dark", pll_en, 0);
    rate_toggle = ~rate_toggle;
    step();
    rate_toggle = ~rate_toggle;
    step();
    stage_div = pat(203);
    strobe();
    chk("R8 pll_en after first", pll_en, 1);
    chk("R8 busy still pending", busy, 1);
    chk("R8 active after first", active_div, exp_act);
    vblank = 1'b0;
    step(3);
    chk("R8 waits for next rise", pll_en, 1);
    vblank = 1'b1;
    step();
    exp_act = pat(203);
    chk("R8 queued start", pll_en, 0);
    chk("R8 queued load", active_div, exp_act);
    strobe();
    chk("R8 queued done busy", busy, 0);
    vblank = 1'b0;
    step();
    vblank = 1'b1;
    step();
    chk("R8 collapsed to one", pll_en, 1);
    chk("R9 busy no request", busy, 0);
    vblank = 1'b0;
    step();

    // Idle line strobes do nothing
    stage_div = pat(250);
    strobe();
    step();
    chk("R9 pll_en idle strobe", pll_en, 1);
    chk("R9 busy idle strobe", busy, 0);
    chk("R9 active idle strobe", active_div, exp_act);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule